// File: doc/BRIEF.md
# Interleaved Pipelined Accumulator

This block forms several running sums at once from one stream of signed fixed-point operands. Its adder is pipelined over several clock cycles, and the block does not stall to wait for it. Operands arrive interleaved: one element for each of `cfg_lanes` independent sums, then the next element for each of them, and so on for `cfg_passes` rounds. Each partial sum leaves the adder and waits in a small FIFO. It re-enters the adder when the next operand of its lane arrives. This lets the adder take a new operand on every clock.

During the first round, each operand is added to zero. During every later round, each operand is added to the partial sum popped from the FIFO. Partial sums from the final round skip the FIFO and go to a registered output, one per cycle, in lane order. The final sum of the job also carries a last flag. A job begins with the first valid operand presented while the block is idle. The configuration is captured at that point. The block stays busy until its last result has been emitted.

Top module: `acc_fifo_accum`

## Requirements
- R1: During and directly after synchronous reset, `out_valid`, `out_last` and `busy` are 0 and no partial sum is held.
- R2: `busy` rises after the first valid operand is accepted while idle, which starts a job and captures `cfg_lanes` and `cfg_passes`. It stays high until the cycle in which the job's `out_last` is shown, and it is low in that cycle.
- R3: Operand number k of a job (counting from 0) belongs to lane k mod `cfg_lanes` and to round k div `cfg_lanes`. The result for each lane is the two's-complement sum of its sign-extended operands, `DATA_W + clog2(MAX_PASSES)` bits wide, so a full-scale job does not overflow.
- R4: A job produces exactly `cfg_lanes` results, emitted in lane order 0 upward. The final result appears `ADD_LAT+1` cycles after the cycle in which the job's last operand is presented.
- R5: `out_last` is high only together with `out_valid`, and only on the result of the highest lane.
- R6: An operand is accepted on every cycle with `in_valid` high while the job still needs operands. Idle cycles inside a job do not change any result.
- R7: With `cfg_passes` = 1, each result equals the sign-extended operand of its lane.
- R8: Valid operands presented while busy, after the job's last operand, are ignored and produce no output.
- R9: A legal job has `ADD_LAT < cfg_lanes <= MAX_LANES` and `1 <= cfg_passes <= MAX_PASSES`. For such jobs the feedback FIFO never overflows, and it is never popped while empty.
- R10: A new job may start in the cycle in which `busy` is first low again. This includes the cycle in which the previous `out_last` is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lanes | input | clog2(MAX_LANES+1) | Number of interleaved sums, captured at job start |
| cfg_passes | input | clog2(MAX_PASSES+1) | Operands per sum, captured at job start |
| in_valid | input | 1 | Operand present |
| in_data | input | DATA_W | Signed operand |
| busy | output | 1 | Job in progress |
| out_valid | output | 1 | Result present |
| out_sum | output | DATA_W+clog2(MAX_PASSES) | Signed final sum of one lane |
| out_last | output | 1 | Result belongs to the highest lane |

## Verification
The assertions assume that every job is legal. The lane count must exceed the adder latency, so that each partial sum is back in the FIFO before its lane comes round again. Both counts must lie within their maxima. The stimulus only starts jobs with such settings. It covers the smallest legal lane count and the largest one, a single round, and the maximum number of rounds at full-scale operands. Configuration inputs are only changed while the block is busy, when they are not sampled.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Sideband travelling with each operand through the adder pipeline
  typedef struct packed {
    logic vld;   // slot carries an operand
    logic fin;   // operand belongs to the final round
    logic lst;   // operand is the very last of the job
  } acc_tag_t;

endpackage

// File: rtl/acc_pipe_add.sv
// Fixed-point adder split into ADD_LAT carry-chained segments, one per
// register stage, so each stage carries only a short slice of the carry.
module acc_pipe_add
  import acc_pkg::*;
#(
  parameter int W       = 22,
  parameter int ADD_LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  acc_tag_t     tag_in,
  output logic [W-1:0] sum,
  output acc_tag_t     tag_out
);

  for (genvar s = 0; s < ADD_LAT; s++) begin : g_stg
    localparam int LO = (s * W) / ADD_LAT;
    localparam int HI = ((s + 1) * W) / ADD_LAT;
    localparam int SW = HI - LO;            // slice width handled here
    localparam int RW = W - LO;             // operand bits still pending
    localparam int CW = (s < ADD_LAT - 1) ? SW + 1 : SW;

    logic [RW-1:0] a_i, b_i;
    logic [W-1:0]  r_i, r_n, r_q;
    logic          c_i;
    acc_tag_t      t_i, t_q;
    logic [CW-1:0] part;

    if (s == 0) begin : g_head
      assign a_i = a;
      assign b_i = b;
      assign r_i = '0;
      assign c_i = 1'b0;
      assign t_i = tag_in;
    end else begin : g_link
      assign a_i = g_stg[s-1].g_keep.a_q;
      assign b_i = g_stg[s-1].g_keep.b_q;
      assign r_i = g_stg[s-1].r_q;
      assign c_i = g_stg[s-1].g_keep.c_q;
      assign t_i = g_stg[s-1].t_q;
    end

    assign part = CW'(a_i[SW-1:0]) + CW'(b_i[SW-1:0]) + CW'(c_i);

    always_comb begin
      r_n        = r_i;
      r_n[HI-1:LO] = part[SW-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) t_q <= '0;
      else     t_q <= t_i;
      r_q <= r_n;
    end

    if (s < ADD_LAT - 1) begin : g_keep
      logic [W-HI-1:0] a_q, b_q;
      logic            c_q;
      always_ff @(posedge clk) begin
        a_q <= a_i[RW-1:SW];
        b_q <= b_i[RW-1:SW];
        c_q <= part[SW];
      end
    end
  end

  assign sum     = g_stg[ADD_LAT-1].r_q;
  assign tag_out = g_stg[ADD_LAT-1].t_q;

endmodule

// File: rtl/acc_fifo.sv
// Feedback store for partial sums; write is synchronous, read is
// combinational from the head so a popped value meets its operand at once.
module acc_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] rd_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] fill;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R9: a legal job never writes into a full store
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (fill < NW'(DEPTH)));

  // R9: each lane's partial sum is back before its next operand arrives
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (fill != '0));

endmodule

// File: rtl/acc_seq.sv
// Lane/round sequencer: decides per operand whether to add to zero or to
// the fed-back partial sum, and tags the final round and final operand.
module acc_seq #(
  parameter int MAX_LANES  = 16,
  parameter int MAX_PASSES = 64,
  parameter int ADD_LAT    = 3,
  localparam int LANE_W    = $clog2(MAX_LANES + 1),
  localparam int PASS_W    = $clog2(MAX_PASSES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LANE_W-1:0] cfg_lanes,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic              done,
  output logic              accept,
  output logic              use_fb,
  output logic              fin_pass,
  output logic              last_op,
  output logic              busy
);

  logic              busy_q, feed_q;
  logic [LANE_W-1:0] lane_q, lanes_q, cur_lane, cur_lanes;
  logic [PASS_W-1:0] pass_q, passes_q, cur_pass, cur_passes;
  logic              lane_wrap;

  assign cur_lanes  = busy_q ? lanes_q  : cfg_lanes;
  assign cur_passes = busy_q ? passes_q : cfg_passes;
  assign cur_lane   = busy_q ? lane_q   : '0;
  assign cur_pass   = busy_q ? pass_q   : '0;

  assign accept    = in_valid && (!busy_q || feed_q);
  assign use_fb    = (cur_pass != '0);
  assign lane_wrap = (cur_lane == cur_lanes - 1'b1);
  assign fin_pass  = (cur_pass == cur_passes - 1'b1);
  assign last_op   = fin_pass && lane_wrap;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      feed_q   <= 1'b0;
      lane_q   <= '0;
      pass_q   <= '0;
      lanes_q  <= '0;
      passes_q <= '0;
    end else begin
      if (accept && !busy_q) begin
        busy_q   <= 1'b1;
        lanes_q  <= cfg_lanes;
        passes_q <= cfg_passes;
      end
      if (done) busy_q <= 1'b0;
      if (accept) begin
        if (last_op) begin
          feed_q <= 1'b0;
          lane_q <= '0;
          pass_q <= '0;
        end else begin
          feed_q <= 1'b1;
          if (lane_wrap) begin
            lane_q <= '0;
            pass_q <= cur_pass + 1'b1;
          end else begin
            lane_q <= cur_lane + 1'b1;
            pass_q <= cur_pass;
          end
        end
      end
    end
  end

  // R9: only legal jobs are started
  a_r9_legal_cfg: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy_q) |->
      (int'(cfg_lanes) > ADD_LAT && int'(cfg_lanes) <= MAX_LANES &&
       int'(cfg_passes) >= 1 && int'(cfg_passes) <= MAX_PASSES));

  // R3: the lane index stays inside the captured lane count
  a_r3_lane_bound: assert property (@(posedge clk) disable iff (rst)
    (busy_q && feed_q) |-> (lane_q < lanes_q && pass_q < passes_q));

endmodule

// File: rtl/acc_fifo_accum.sv
module acc_fifo_accum
  import acc_pkg::*;
#(
  parameter int  DATA_W     = 16,
  parameter int  MAX_LANES  = 16,
  parameter int  MAX_PASSES = 64,
  parameter int  ADD_LAT    = 3,
  localparam int LANE_W     = $clog2(MAX_LANES + 1),
  localparam int PASS_W     = $clog2(MAX_PASSES + 1),
  localparam int SUM_W      = DATA_W + $clog2(MAX_PASSES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] cfg_lanes,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              out_valid,
  output logic [SUM_W-1:0]  out_sum,
  output logic              out_last
);

  logic             accept, use_fb, fin_pass, last_op, done;
  logic [SUM_W-1:0] op_ext, fb_data, add_b, add_sum;
  acc_tag_t         tag_in, tag_out;
  logic             fb_push, fb_pop;
  logic             out_valid_q, out_last_q;
  logic [SUM_W-1:0] out_sum_q;

  acc_seq #(
    .MAX_LANES (MAX_LANES),
    .MAX_PASSES(MAX_PASSES),
    .ADD_LAT   (ADD_LAT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cfg_lanes (cfg_lanes),
    .cfg_passes(cfg_passes),
    .done      (done),
    .accept    (accept),
    .use_fb    (use_fb),
    .fin_pass  (fin_pass),
    .last_op   (last_op),
    .busy      (busy)
  );

  assign op_ext = {{(SUM_W - DATA_W){in_data[DATA_W-1]}}, in_data};
  assign add_b  = use_fb ? fb_data : '0;
  assign fb_pop = accept && use_fb;
  assign tag_in = '{vld: accept, fin: fin_pass, lst: last_op};

  acc_pipe_add #(
    .W      (SUM_W),
    .ADD_LAT(ADD_LAT)
  ) u_add (
    .clk    (clk),
    .rst    (rst),
    .a      (op_ext),
    .b      (add_b),
    .tag_in (tag_in),
    .sum    (add_sum),
    .tag_out(tag_out)
  );

  assign fb_push = tag_out.vld && !tag_out.fin;
  assign done    = tag_out.vld && tag_out.fin && tag_out.lst;

  acc_fifo #(
    .W    (SUM_W),
    .DEPTH(MAX_LANES)
  ) u_fb (
    .clk    (clk),
    .rst    (rst),
    .push   (fb_push),
    .wr_data(add_sum),
    .pop    (fb_pop),
    .rd_data(fb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_sum_q   <= '0;
    end else begin
      out_valid_q <= tag_out.vld && tag_out.fin;
      out_last_q  <= done;
      if (tag_out.vld && tag_out.fin) out_sum_q <= add_sum;
    end
  end

  assign out_valid = out_valid_q;
  assign out_last  = out_last_q;
  assign out_sum   = out_sum_q;

  // R5: the last flag never stands alone
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R2: busy only ends with the job's last result
  a_r2_busy_ends_on_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_last);

  // R4: results only come out of a running job
  a_r4_result_in_job: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

endmodule

// File: tb/tb_acc_fifo_accum.sv
module tb_acc_fifo_accum;

  localparam int DW  = 16;
  localparam int ML  = 16;
  localparam int MP  = 64;
  localparam int LAT = 3;
  localparam int LW  = $clog2(ML + 1);
  localparam int PW  = $clog2(MP + 1);
  localparam int SW  = DW + $clog2(MP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] cfg_lanes = '0;
  logic [PW-1:0] cfg_passes = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          busy, out_valid, out_last;
  logic [SW-1:0] out_sum;

  acc_fifo_accum #(
    .DATA_W(DW), .MAX_LANES(ML), .MAX_PASSES(MP), .ADD_LAT(LAT)
  ) dut (
    .clk(clk), .rst(rst), .cfg_lanes(cfg_lanes), .cfg_passes(cfg_passes),
    .in_valid(in_valid), .in_data(in_data), .busy(busy),
    .out_valid(out_valid), .out_sum(out_sum), .out_last(out_last)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int nres   = 0;
  logic [SW-1:0] res_sum  [64];
  logic          res_last [64];
  int            res_cyc  [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (nres < 64) begin
        res_sum[nres]  = out_sum;
        res_last[nres] = out_last;
        res_cyc[nres]  = cyc;
      end
      nres = nres + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int opval(int k, int seed);
    if (seed < 0) return (k % 2 == 0) ? -32768 : 32767;
    return ((k * 37 + seed * 101) % 4001) - 2000;
  endfunction

  // Drives one job, then checks count, values, order, last flag, latency.
  task automatic run_job(input int lanes, input int passes, input int seed,
                         input int gap_mod, input int extra, input bit settle,
                         input string req);
    longint exp_sum [ML];
    int last_edge = 0;
    for (int j = 0; j < ML; j++) exp_sum[j] = 0;
    nres = 0;
    for (int k = 0; k < lanes * passes; k++) begin
      if (gap_mod > 0 && (k % gap_mod) == gap_mod - 1) begin
        in_valid = 1'b0;
        @(negedge clk); #1;
      end
      cfg_lanes  = LW'(lanes);
      cfg_passes = PW'(passes);
      in_valid   = 1'b1;
      in_data    = DW'(opval(k, seed));
      exp_sum[k % lanes] += longint'(opval(k, seed));
      last_edge  = cyc + 1;
      @(negedge clk); #1;
      if (k == 0) chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    end
    for (int e = 0; e < extra; e++) begin
      in_valid   = 1'b1;
      in_data    = DW'(12345);
      cfg_lanes  = LW'(7);
      cfg_passes = PW'(2);
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
    while (busy) begin
      @(negedge clk); #1;
    end
    chk(out_last == 1'b1, "R2", "out_last in cycle busy drops", out_last, 1);
    if (settle) begin
      repeat (LAT + 4) @(negedge clk);
      #1;
    end
    chk(nres == lanes, req, "result count", nres, lanes);
    for (int j = 0; j < lanes && j < nres; j++) begin
      logic [SW-1:0] e = exp_sum[j][SW-1:0];
      chk(res_sum[j] == e, req, $sformatf("lane %0d sum", j),
          longint'($signed(res_sum[j])), longint'($signed(e)));
      chk(res_last[j] == (j == lanes - 1), "R5", $sformatf("lane %0d last", j),
          res_last[j], (j == lanes - 1));
    end
    if (nres >= lanes)
      chk(res_cyc[lanes-1] == last_edge + LAT, "R4", "final result latency",
          res_cyc[lanes-1], last_edge + LAT);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1", "outputs after reset",
        out_valid, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
  endtask

  task automatic t_basic;        run_job(4, 5, 1, 0, 0, 1, "R3"); endtask
  task automatic t_max_lanes;    run_job(ML, 8, 2, 0, 0, 1, "R3"); endtask
  task automatic t_min_lanes;    run_job(LAT + 1, 6, 3, 0, 0, 1, "R6"); endtask
  task automatic t_gaps;         run_job(5, 7, 4, 3, 0, 1, "R6"); endtask
  task automatic t_single_pass;  run_job(6, 1, 5, 0, 0, 1, "R7"); endtask
  task automatic t_extra;        run_job(4, 3, 6, 0, 2, 1, "R8"); endtask
  task automatic t_full_scale;   run_job(4, MP, -1, 0, 0, 1, "R3"); endtask

  task automatic t_back_to_back;
    run_job(5, 3, 7, 0, 0, 0, "R10");
    run_job(4, 4, 8, 0, 0, 1, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_max_lanes();
    t_min_lanes();
    t_gaps();
    t_single_pass();
    t_extra();
    t_full_scale();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule